// File: doc/BRIEF.md
# Virtual-Channel Router Input Unit with Lookahead XY Routing

This block is one input port of a router in a two-dimensional mesh network on chip. Each cycle it may accept one 32-bit flit from the upstream link. It writes the flit into the virtual-channel FIFO named by the channel field inside the flit. The upstream sender never overruns a FIFO, because a credit comes back each time a flit leaves.

Routing is done one hop ahead. A head flit arrives already carrying the output port it must take at this router. As the head is written, the unit works out where the next router will be and which port the packet will need there, using X-then-Y dimension-ordered routing. It writes that port into the head flit's port field. The port for this router is stored beside every flit of the packet, so the allocators can read it from the front of each FIFO. Body and tail flits take the port of their own head.

Each channel runs a two-state machine. VC_IDLE moves to VC_ACTIVE on transition T_OPEN, which is an accepted head or single flit. VC_ACTIVE moves back to VC_IDLE on transition T_CLOSE, which is the dequeue of a tail or single flit in a cycle with no T_OPEN. In every other case the state holds.

Top module: `vc_input_unit`

## Requirements
- R1: While reset is low and in the first cycle after it, out_valid, vc_active, credit_valid and overflow_err are all 0.
- R2: An accepted flit goes to the FIFO selected by bits [29:28]. Each FIFO delivers its flits in arrival order. out_valid[v] is high while FIFO v holds a flit.
- R3: For a head flit (type bits [31:30] = 00) or a single flit (type 11), the port field [27:25] is replaced by the port needed at the next router. The port encoding is Local=0, North=1, East=2, South=3, West=4. Going East raises X by one and going North raises Y by one. The destination X is in [24:22] and the destination Y is in [21:19]. The next port is East or West until X matches, then North or South until Y matches, then Local. A flit whose port here is Local keeps Local.
- R4: out_port shows the port to use at this router. For a head or single flit this is its original field [27:25]. A body flit (01) or tail flit (10) shows the port of the most recent head accepted on its channel before it.
- R5: Body and tail flits are stored and presented with all 32 bits unchanged.
- R6: vc_active[v] follows the VC_IDLE/VC_ACTIVE machine: T_OPEN on an accepted head or single flit, and T_CLOSE on a dequeued tail or single flit. The dequeue of a head flit does not close the channel.
- R7: In the cycle after a flit is dequeued, credit_valid is high for exactly one cycle, with credit_vc set to that channel.
- R8: Only the lowest-index channel whose deq_req bit is set and which holds a flit is dequeued. A request on an empty channel is ignored and gives no credit.
- R9: A flit sent to a full FIFO is dropped and sets overflow_err. overflow_err then stays high until reset.
- R10: A flit accepted at a clock edge is visible at the FIFO output after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Flit present on in_flit |
| in_flit | input | 32 | Incoming flit |
| deq_req | input | NUM_VC | Per-channel dequeue request |
| out_valid | output | NUM_VC | Channel FIFO non-empty |
| out_flit | output | 32*NUM_VC | Front flit of each channel, channel v at bits [32v+31:32v] |
| out_port | output | 3*NUM_VC | Port to use at this router for each front flit |
| vc_active | output | NUM_VC | Per-channel packet state (1 = VC_ACTIVE) |
| credit_valid | output | 1 | One-cycle credit pulse to upstream |
| credit_vc | output | 2 | Channel the credit belongs to |
| overflow_err | output | 1 | Sticky write-into-full flag |

## Verification
The bench checks the lookahead port in every compass direction and covers the cases where the X coordinate already matches, where the packet arrives at the next node, and where the port here is Local. If the design used the current node's coordinates instead of the next node's, the stored head field would come out wrong. It sends body and tail flits interleaved with heads on other channels, so a design that kept one shared route register would give the wrong out_port. It sets two dequeue bits at once, once including an empty channel, so a design with the wrong priority would pop the wrong FIFO or send the wrong credit tag. It also overfills one FIFO: a design that wrote the extra flit anyway would leave a flit behind after draining, and a design whose error flag was not sticky would drop the flag.

// File: rtl/vcin_pkg.sv
package vcin_pkg;
    localparam int FLIT_W  = 32;
    localparam int VC_FW   = 2;
    localparam int PORT_W  = 3;
    localparam int COORD_W = 3;
    localparam int ENTRY_W = FLIT_W + PORT_W;

    // field positions inside a flit
    localparam int KIND_LO = 30;
    localparam int VC_LO   = 28;
    localparam int PORT_LO = 25;
    localparam int DX_LO   = 22;
    localparam int DY_LO   = 19;

    typedef enum logic [1:0] {
        FT_HEAD   = 2'b00,
        FT_BODY   = 2'b01,
        FT_TAIL   = 2'b10,
        FT_SINGLE = 2'b11
    } flit_kind_e;

    typedef enum logic [2:0] {
        P_LOCAL = 3'd0,
        P_NORTH = 3'd1,
        P_EAST  = 3'd2,
        P_SOUTH = 3'd3,
        P_WEST  = 3'd4
    } port_e;

    typedef enum logic {
        VC_IDLE   = 1'b0,
        VC_ACTIVE = 1'b1
    } vc_state_e;
endpackage

// File: rtl/la_route.sv
module la_route
    import vcin_pkg::*;
#(
    parameter int MY_X = 2,
    parameter int MY_Y = 2
) (
    input  logic [PORT_W-1:0]  cur_port,
    input  logic [COORD_W-1:0] dst_x,
    input  logic [COORD_W-1:0] dst_y,
    output logic [PORT_W-1:0]  nxt_port
);
    localparam int CW1 = COORD_W + 1;

    logic [CW1-1:0] nx, ny, dx, dy;

    always_comb begin
        nx = CW1'(MY_X);
        ny = CW1'(MY_Y);
        case (cur_port)
            P_EAST:  nx = nx + CW1'(1);
            P_WEST:  nx = nx - CW1'(1);
            P_NORTH: ny = ny + CW1'(1);
            P_SOUTH: ny = ny - CW1'(1);
            default: ;
        endcase
        dx = {1'b0, dst_x};
        dy = {1'b0, dst_y};
        if (cur_port == P_LOCAL) nxt_port = P_LOCAL;
        else if (dx > nx)        nxt_port = P_EAST;
        else if (dx < nx)        nxt_port = P_WEST;
        else if (dy > ny)        nxt_port = P_NORTH;
        else if (dy < ny)        nxt_port = P_SOUTH;
        else                     nxt_port = P_LOCAL;
    end
endmodule

// File: rtl/vc_fifo.sv
module vc_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 35
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wp] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (wr_en) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
            if (rd_en) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
            case ({wr_en, rd_en})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: ;
            endcase
        end
    end

    assign rd_data = mem[rp];
    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
endmodule

// File: rtl/vc_state.sv
module vc_state
    import vcin_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic open_i,
    input  logic close_i,
    output logic active_o
);
    vc_state_e st, st_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= VC_IDLE;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            VC_IDLE:   if (open_i)              st_nxt = VC_ACTIVE; // T_OPEN
            VC_ACTIVE: if (close_i && !open_i)  st_nxt = VC_IDLE;   // T_CLOSE
        endcase
    end

    always_comb active_o = (st == VC_ACTIVE);
endmodule

// File: rtl/vc_input_unit.sv
module vc_input_unit
    import vcin_pkg::*;
#(
    parameter int NUM_VC     = 4,
    parameter int FIFO_DEPTH = 4,
    parameter int MY_X       = 2,
    parameter int MY_Y       = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [31:0]              in_flit,
    input  logic [NUM_VC-1:0]        deq_req,
    output logic [NUM_VC-1:0]        out_valid,
    output logic [NUM_VC*32-1:0]     out_flit,
    output logic [NUM_VC*3-1:0]      out_port,
    output logic [NUM_VC-1:0]        vc_active,
    output logic                     credit_valid,
    output logic [1:0]               credit_vc,
    output logic                     overflow_err
);
    flit_kind_e          in_kind;
    logic [VC_FW-1:0]    in_vc;
    logic                in_is_head;
    logic [PORT_W-1:0]   la_port;
    logic [FLIT_W-1:0]   wr_flit;
    logic [NUM_VC-1:0]   full, empty, grant, ovf_hit;
    logic [VC_FW-1:0]    gvc;

    assign in_kind    = flit_kind_e'(in_flit[KIND_LO +: 2]);
    assign in_vc      = in_flit[VC_LO +: VC_FW];
    assign in_is_head = (in_kind == FT_HEAD) || (in_kind == FT_SINGLE);

    la_route #(.MY_X(MY_X), .MY_Y(MY_Y)) u_la (
        .cur_port (in_flit[PORT_LO +: PORT_W]),
        .dst_x    (in_flit[DX_LO +: COORD_W]),
        .dst_y    (in_flit[DY_LO +: COORD_W]),
        .nxt_port (la_port)
    );

    assign wr_flit = in_is_head
        ? {in_flit[31:PORT_LO+PORT_W], la_port, in_flit[PORT_LO-1:0]}
        : in_flit;

    // lowest-index requesting channel that holds a flit wins
    always_comb begin
        grant = '0;
        gvc   = '0;
        for (int v = NUM_VC - 1; v >= 0; v--) begin
            if (deq_req[v] && !empty[v]) begin
                grant = NUM_VC'(1) << v;
                gvc   = VC_FW'(v);
            end
        end
    end

    for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
        logic               sel, wr_ok, open_c, close_c;
        logic [PORT_W-1:0]  route_q, entry_port;
        logic [ENTRY_W-1:0] rd_e;
        flit_kind_e         rd_kind;

        assign sel        = in_valid && (in_vc == VC_FW'(v));
        assign wr_ok      = sel && !full[v];
        assign ovf_hit[v] = sel && full[v];
        assign entry_port = in_is_head ? in_flit[PORT_LO +: PORT_W] : route_q;

        always_ff @(posedge clk) begin
            if (!rst_n)                   route_q <= P_LOCAL;
            else if (wr_ok && in_is_head) route_q <= in_flit[PORT_LO +: PORT_W];
        end

        vc_fifo #(.DEPTH(FIFO_DEPTH), .W(ENTRY_W)) u_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_ok),
            .wr_data ({entry_port, wr_flit}),
            .rd_en   (grant[v]),
            .rd_data (rd_e),
            .empty   (empty[v]),
            .full    (full[v])
        );

        assign rd_kind = flit_kind_e'(rd_e[KIND_LO +: 2]);
        assign open_c  = wr_ok && in_is_head;
        assign close_c = grant[v] && ((rd_kind == FT_TAIL) || (rd_kind == FT_SINGLE));

        vc_state u_st (
            .clk      (clk),
            .rst_n    (rst_n),
            .open_i   (open_c),
            .close_i  (close_c),
            .active_o (vc_active[v])
        );

        assign out_valid[v]         = !empty[v];
        assign out_flit[v*32 +: 32] = rd_e[FLIT_W-1:0];
        assign out_port[v*3 +: 3]   = rd_e[ENTRY_W-1:FLIT_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            credit_valid <= 1'b0;
            credit_vc    <= '0;
            overflow_err <= 1'b0;
        end else begin
            credit_valid <= |grant;
            credit_vc    <= gvc;
            if (|ovf_hit) overflow_err <= 1'b1;
        end
    end
endmodule

// File: rtl/vc_input_unit_chk.sv
module vc_input_unit_chk #(
    parameter int NUM_VC = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [31:0]       in_flit,
    input logic [NUM_VC-1:0] deq_req,
    input logic [NUM_VC-1:0] out_valid,
    input logic [NUM_VC-1:0] vc_active,
    input logic              credit_valid,
    input logic [1:0]        credit_vc,
    input logic              overflow_err
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!credit_valid && !overflow_err && out_valid == '0 && vc_active == '0));

    p_credit_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        credit_valid |-> $past((deq_req & out_valid) != '0));

    p_no_req_no_credit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((deq_req & out_valid) == '0) |=> !credit_valid);

    p_credit_tag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        credit_valid |-> (32'(credit_vc) < NUM_VC));

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_err |=> overflow_err);

    p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow_err) |-> $past(in_valid));

    p_open_on_head_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_flit[31] == in_flit[30]))
            |=> (vc_active[$past(in_flit[29:28])] || overflow_err));
endmodule

bind vc_input_unit vc_input_unit_chk #(.NUM_VC(NUM_VC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_flit      (in_flit),
    .deq_req      (deq_req),
    .out_valid    (out_valid),
    .vc_active    (vc_active),
    .credit_valid (credit_valid),
    .credit_vc    (credit_vc),
    .overflow_err (overflow_err)
);

// File: tb/test_vc_input_unit.sv
module test_vc_input_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [31:0]   in_flit = '0;
    logic [NV-1:0] deq_req = '0;
    logic [NV-1:0] out_valid, vc_active;
    logic [NV*32-1:0] out_flit;
    logic [NV*3-1:0]  out_port;
    logic          credit_valid, overflow_err;
    logic [1:0]    credit_vc;

    int n_tests = 0;
    int n_fail  = 0;
    logic [34:0] exp_q [NV][$];

    always #(CLK_PERIOD/2) clk = ~clk;

    vc_input_unit #(.NUM_VC(NV), .FIFO_DEPTH(4), .MY_X(2), .MY_Y(2)) i_vc_input_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flit(in_flit),
        .deq_req(deq_req), .out_valid(out_valid), .out_flit(out_flit),
        .out_port(out_port), .vc_active(vc_active), .credit_valid(credit_valid),
        .credit_vc(credit_vc), .overflow_err(overflow_err)
    );

    task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // kind, vc, port here, dst x, dst y, packet id; source fixed at (2,2)
    function automatic logic [31:0] hd(input logic [1:0] k, input logic [1:0] vc,
            input logic [2:0] p, input logic [2:0] dx, input logic [2:0] dy, input logic [7:0] id);
        return {k, vc, p, dx, dy, 3'd2, 3'd2, id, 5'd0};
    endfunction

    function automatic logic [31:0] bd(input logic [1:0] k, input logic [1:0] vc, input logic [27:0] pay);
        return {k, vc, pay};
    endfunction

    // driver: pushes the expected {port here, stored flit} when keep is set
    task automatic send(input logic [31:0] f, input logic [31:0] ef, input logic [2:0] ep, input bit keep);
        @(negedge clk);
        in_valid = 1'b1;
        in_flit  = f;
        if (keep) exp_q[f[29:28]].push_back({ep, ef});
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // monitor: compares the front of channel v against the scoreboard, dequeues it
    task automatic pop(input int v);
        logic [34:0] e;
        @(negedge clk);
        e = exp_q[v].pop_front();
        check(out_valid[v], "R2 front valid", 64'(out_valid), 64'(1 << v));
        check({out_port[v*3 +: 3], out_flit[v*32 +: 32]} == e, "R3 R4 R5 scoreboard",
              64'({out_port[v*3 +: 3], out_flit[v*32 +: 32]}), 64'(e));
        deq_req = NV'(1 << v);
        @(negedge clk);
        deq_req = '0;
        check(credit_valid && credit_vc == 2'(v), "R7 credit tag", 64'({credit_valid, credit_vc}), 64'({1'b1, 2'(v)}));
    endtask

    initial begin
        logic [34:0] e;
        repeat (3) @(negedge clk);
        check(out_valid == '0 && vc_active == '0 && !credit_valid && !overflow_err, "R1 reset",
              64'({out_valid, vc_active, credit_valid, overflow_err}), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == '0 && vc_active == '0 && !credit_valid && !overflow_err, "R1 after reset",
              64'({out_valid, vc_active, credit_valid, overflow_err}), 64'(0));

        // heads on all channels; lookahead port expectations
        send(hd(2'b00, 2'd0, 3'd2, 3'd4, 3'd2, 8'h11), hd(2'b00, 2'd0, 3'd2, 3'd4, 3'd2, 8'h11), 3'd2, 1);
        check(out_valid == 4'b0001, "R10 visible next cycle", 64'(out_valid), 64'h1);
        send(hd(2'b00, 2'd1, 3'd1, 3'd2, 3'd4, 8'h22), hd(2'b00, 2'd1, 3'd1, 3'd2, 3'd4, 8'h22), 3'd1, 1);
        send(hd(2'b00, 2'd2, 3'd4, 3'd0, 3'd3, 8'h33), hd(2'b00, 2'd2, 3'd4, 3'd0, 3'd3, 8'h33), 3'd4, 1);
        send(hd(2'b00, 2'd3, 3'd2, 3'd3, 3'd0, 8'h44), hd(2'b00, 2'd3, 3'd3, 3'd3, 3'd0, 8'h44), 3'd2, 1);
        check(vc_active == 4'b1111, "R6 heads open channels", 64'(vc_active), 64'hf);
        check(out_valid == 4'b1111, "R2 per-channel fifos", 64'(out_valid), 64'hf);

        // bodies and tails interleaved across channels
        send(bd(2'b01, 2'd0, 28'h0abcdef), bd(2'b01, 2'd0, 28'h0abcdef), 3'd2, 1);
        send(bd(2'b10, 2'd1, 28'h1234567), bd(2'b10, 2'd1, 28'h1234567), 3'd1, 1);
        send(bd(2'b10, 2'd0, 28'hfedcba9), bd(2'b10, 2'd0, 28'hfedcba9), 3'd2, 1);

        for (int i = 0; i < 3; i++) pop(0);
        @(negedge clk);
        check(!credit_valid, "R7 single-cycle pulse", 64'(credit_valid), 64'h0);
        pop(1); pop(1);
        pop(2); pop(3);
        @(negedge clk);
        check(vc_active == 4'b1100, "R6 tail closes, head departure keeps", 64'(vc_active), 64'hc);

        // single flits and lookahead corners
        send(hd(2'b11, 2'd2, 3'd2, 3'd3, 3'd2, 8'h55), hd(2'b11, 2'd2, 3'd0, 3'd3, 3'd2, 8'h55), 3'd2, 1);
        send(hd(2'b11, 2'd3, 3'd0, 3'd2, 3'd2, 8'h66), hd(2'b11, 2'd3, 3'd0, 3'd2, 3'd2, 8'h66), 3'd0, 1);
        send(hd(2'b11, 2'd3, 3'd1, 3'd2, 3'd3, 8'h77), hd(2'b11, 2'd3, 3'd0, 3'd2, 3'd3, 8'h77), 3'd1, 1);
        send(hd(2'b11, 2'd1, 3'd3, 3'd0, 3'd1, 8'h88), hd(2'b11, 2'd1, 3'd4, 3'd0, 3'd1, 8'h88), 3'd3, 1);
        check(vc_active == 4'b1110, "R6 single opens", 64'(vc_active), 64'he);
        pop(2); pop(3); pop(3); pop(1);
        @(negedge clk);
        check(vc_active == 4'b0000, "R6 single departure closes", 64'(vc_active), 64'h0);

        // R8: multiple requests and empty requests
        send(hd(2'b00, 2'd1, 3'd2, 3'd4, 3'd4, 8'h99), hd(2'b00, 2'd1, 3'd2, 3'd4, 3'd4, 8'h99), 3'd2, 1);
        send(hd(2'b00, 2'd2, 3'd1, 3'd2, 3'd4, 8'haa), hd(2'b00, 2'd2, 3'd1, 3'd2, 3'd4, 8'haa), 3'd1, 1);
        @(negedge clk);
        e = exp_q[1].pop_front();
        check({out_port[5:3], out_flit[63:32]} == e, "R3 scoreboard vc1", 64'({out_port[5:3], out_flit[63:32]}), 64'(e));
        deq_req = 4'b0110;
        @(negedge clk);
        deq_req = '0;
        check(credit_valid && credit_vc == 2'd1, "R8 lowest wins credit", 64'({credit_valid, credit_vc}), 64'h5);
        check(out_valid == 4'b0100, "R8 only lowest popped", 64'(out_valid), 64'h4);
        e = exp_q[2].pop_front();
        check({out_port[8:6], out_flit[95:64]} == e, "R3 scoreboard vc2", 64'({out_port[8:6], out_flit[95:64]}), 64'(e));
        deq_req = 4'b0101;
        @(negedge clk);
        deq_req = '0;
        check(credit_valid && credit_vc == 2'd2, "R8 empty lower skipped", 64'({credit_valid, credit_vc}), 64'h6);
        check(out_valid == 4'b0000, "R8 vc2 drained", 64'(out_valid), 64'h0);
        deq_req = 4'b0001;
        @(negedge clk);
        deq_req = '0;
        check(!credit_valid, "R8 empty request no credit", 64'(credit_valid), 64'h0);

        // R9: overflow
        send(hd(2'b00, 2'd0, 3'd4, 3'd0, 3'd0, 8'hbb), hd(2'b00, 2'd0, 3'd4, 3'd0, 3'd0, 8'hbb), 3'd4, 1);
        for (int i = 0; i < 3; i++)
            send(bd(2'b01, 2'd0, 28'(i + 1)), bd(2'b01, 2'd0, 28'(i + 1)), 3'd4, 1);
        check(!overflow_err, "R9 no error when just full", 64'(overflow_err), 64'h0);
        send(bd(2'b10, 2'd0, 28'h7777777), 32'h0, 3'd0, 0);
        check(overflow_err, "R9 overflow flagged", 64'(overflow_err), 64'h1);
        for (int i = 0; i < 4; i++) pop(0);
        @(negedge clk);
        check(out_valid[0] == 1'b0, "R9 extra flit dropped", 64'(out_valid), 64'h0);
        check(overflow_err, "R9 flag sticky", 64'(overflow_err), 64'h1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule